// File: doc/BRIEF.md
# Virtual Address Translation and Fault Classifier

This stage sits between a translation lookaside array and the load/store and fetch pipes. Each request carries a 32-bit virtual address, an address-space identifier, an access kind (fetch, load, store), a kernel-mode flag and a misalignment flag. The lookup result for that address arrives with it: a hit flag, a page-size code, and the two frame numbers of the entry pair with their valid and dirty bits.

The stage sorts the address into a segment. The two unmapped kernel windows are translated directly and skip the lookup result. Every other address goes through the entry: one address bit chooses the even or odd half, that half is checked for valid and, on stores, for dirty, and the physical address is built from it. The result is one registered word, presented one cycle after the request. It holds a physical address with an uncacheable flag, or one fault code with the fields a handler needs to reload the entry.

Top module: `va_xlate`

## Requirements
- R1: `res_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. All other result outputs update only when a request is taken and hold their values between requests.
- R2: Addresses with bits [31:29] = 3'b101 are mapped directly to {3'b000, vaddr[28:0]}, with `res_uncached` = 1 and no fault. The mode, the misalignment flag and the lookup result have no effect on these addresses.
- R3: Addresses with bits [31:29] = 3'b100 are mapped directly to {3'b000, vaddr[28:0]} with `res_uncached` = 0 when the access is in kernel mode and aligned. If the access is not in kernel mode or is misaligned, the stage raises an address error: code 1 for a fetch, code 2 for a load or store.
- R4: In the mapped segments, a misaligned access raises an address error (code 1 fetch, code 2 data), whether or not the lookup hits.
- R5: A mapped, aligned access whose lookup misses raises a refill fault: code 3 for a fetch, code 4 for data.
- R6: The half is chosen by virtual address bit 12+2*`tlb_size`, where size codes above 6 count as 6. A 1 selects the odd half and a 0 selects the even half.
- R7: A hit whose selected half has its valid bit clear raises an invalid fault: code 5 for a fetch, code 6 for data. This takes priority over the dirty check.
- R8: A store that hits a valid half with its dirty bit clear raises a modified fault (code 7). A load or fetch that hits such a half translates normally.
- R9: A successful mapped translation gives `res_paddr` = ({pfn, 12'b0} with the low 12+2*size bits cleared) OR (vaddr with only those low bits kept).
- R10: On a successful translation, `res_uncached` equals vaddr[31] AND vaddr[29]. On any fault, `res_paddr` and `res_uncached` are 0.
- R11: Faults with codes 3 to 7 report `rpt_asid` = request ASID, `rpt_vpn2` = `rpt_ctx_vpn2` = vaddr[31:13], and `rpt_vpn2x` = 0 (or vaddr[12:11] when SMALL_PAGES=1). Every fault reports `rpt_badva` = vaddr. An address error leaves the other report fields at 0, and with no fault all report fields are 0.
- R12: After reset, `res_valid` = 0, `res_fault` = 0 (no fault), and all address and report outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store (3 counts as load) |
| req_kmode | input | 1 | Requester is in kernel mode |
| req_misalign | input | 1 | Address is not aligned to the access size |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_size | input | 3 | Page-size code; the page is 4 KiB << (2*code) |
| tlb_pfn_even | input | 20 | Frame number of the even half |
| tlb_pfn_odd | input | 20 | Frame number of the odd half |
| tlb_v_even | input | 1 | Even half valid |
| tlb_v_odd | input | 1 | Odd half valid |
| tlb_d_even | input | 1 | Even half writable (dirty) |
| tlb_d_odd | input | 1 | Odd half writable (dirty) |
| res_valid | output | 1 | Result presented |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_uncached | output | 1 | Access bypasses the cache |
| res_fault | output | 3 | 0 none, 1 fetch address error, 2 data address error, 3 fetch refill, 4 data refill, 5 fetch invalid, 6 data invalid, 7 modified |
| rpt_badva | output | 32 | Faulting virtual address |
| rpt_asid | output | 8 | ASID reported on lookup faults |
| rpt_vpn2 | output | 19 | Page-pair number reported on lookup faults |
| rpt_vpn2x | output | 2 | Extra page-number bits for small pages |
| rpt_ctx_vpn2 | output | 19 | Page-pair number for the context field |

## Verification
The hardest case to reach is a request where several fault causes apply at once. Examples are a misaligned access that also misses, and a store to a half that is both invalid and clean. Only the highest-priority code may appear in these cases. The bench sets up each such overlap on purpose and checks that exactly one code comes out. It also uses size code 1, where an address bit other than bit 12 chooses the half, so a design that always tests bit 12 gives a wrong frame.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ADDR_I   = 3'd1,
    FLT_ADDR_D   = 3'd2,
    FLT_REFILL_I = 3'd3,
    FLT_REFILL_D = 3'd4,
    FLT_INVAL_I  = 3'd5,
    FLT_INVAL_D  = 3'd6,
    FLT_MODIFIED = 3'd7
  } flt_e;

  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'd0,
    SEG_DIRECT_C = 2'd1,
    SEG_DIRECT_U = 2'd2
  } seg_e;
endpackage

// File: rtl/va_seg_dec.sv
module va_seg_dec
  import va_xlate_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  output seg_e            seg,
  output logic [PA_W-1:0] direct_pa,
  output logic            uc_bits
);
  localparam int LOW_W = VA_W - 3;

  logic [2:0] top3;

  always_comb begin
    top3 = vaddr[VA_W-1 -: 3];
    unique case (top3)
      3'b100:  seg = SEG_DIRECT_C;
      3'b101:  seg = SEG_DIRECT_U;
      default: seg = SEG_MAPPED;
    endcase
    direct_pa = PA_W'(vaddr[LOW_W-1:0]);
    uc_bits   = top3[2] & top3[0];
  end
endmodule

// File: rtl/va_half_sel.sv
module va_half_sel #(
  parameter int VA_W   = 32,
  parameter int PFN_W  = 20,
  parameter int SZ_W   = 3,
  parameter int MAX_SZ = 6
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [SZ_W-1:0]       size_code,
  input  logic [PFN_W-1:0]      pfn_even,
  input  logic [PFN_W-1:0]      pfn_odd,
  input  logic                  v_even,
  input  logic                  v_odd,
  input  logic                  d_even,
  input  logic                  d_odd,
  output logic                  sel_valid,
  output logic                  sel_dirty,
  output logic [PFN_W+11:0]     pa
);
  localparam int PA_W = PFN_W + 12;

  logic [SZ_W-1:0] code_c;
  logic [5:0]      sh;
  logic [VA_W-1:0] shifted;
  logic            odd;
  logic [PA_W-1:0] offmask;
  logic [PA_W-1:0] frame;
  logic [PA_W-1:0] va_ext;

  always_comb begin
    code_c  = (size_code > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : size_code;
    sh      = 6'd12 + (6'(code_c) << 1);
    shifted = vaddr >> sh;
    odd     = shifted[0];
    offmask = (PA_W'(1) << sh) - PA_W'(1);
    frame   = {(odd ? pfn_odd : pfn_even), 12'b0};
    va_ext  = PA_W'(vaddr);
    pa        = (frame & ~offmask) | (va_ext & offmask);
    sel_valid = odd ? v_odd : v_even;
    sel_dirty = odd ? d_odd : d_even;
  end
endmodule

// File: rtl/va_fault_cls.sv
module va_fault_cls
  import va_xlate_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] acc,
  input  logic       kmode,
  input  logic       misalign,
  input  logic       hit,
  input  logic       sel_valid,
  input  logic       sel_dirty,
  output flt_e       fault,
  output logic       tlb_fault
);
  logic is_fetch;
  logic is_store;

  always_comb begin
    is_fetch = (acc == ACC_FETCH);
    is_store = (acc == ACC_STORE);
    fault    = FLT_NONE;
    unique case (seg)
      SEG_DIRECT_U: fault = FLT_NONE;
      SEG_DIRECT_C: begin
        if (!kmode || misalign) fault = is_fetch ? FLT_ADDR_I : FLT_ADDR_D;
      end
      default: begin
        if (misalign)               fault = is_fetch ? FLT_ADDR_I : FLT_ADDR_D;
        else if (!hit)              fault = is_fetch ? FLT_REFILL_I : FLT_REFILL_D;
        else if (!sel_valid)        fault = is_fetch ? FLT_INVAL_I : FLT_INVAL_D;
        else if (is_store && !sel_dirty) fault = FLT_MODIFIED;
      end
    endcase
    tlb_fault = (fault >= FLT_REFILL_I);
  end
endmodule

// File: rtl/va_xlate.sv
module va_xlate
  import va_xlate_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int PFN_W       = 20,
  parameter int SZ_W        = 3,
  parameter int MAX_SZ      = 6,
  parameter bit SMALL_PAGES = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic [1:0]           req_acc,
  input  logic                 req_kmode,
  input  logic                 req_misalign,
  input  logic                 tlb_hit,
  input  logic [SZ_W-1:0]      tlb_size,
  input  logic [PFN_W-1:0]     tlb_pfn_even,
  input  logic [PFN_W-1:0]     tlb_pfn_odd,
  input  logic                 tlb_v_even,
  input  logic                 tlb_v_odd,
  input  logic                 tlb_d_even,
  input  logic                 tlb_d_odd,
  output logic                 res_valid,
  output logic [PFN_W+11:0]    res_paddr,
  output logic                 res_uncached,
  output logic [2:0]           res_fault,
  output logic [VA_W-1:0]      rpt_badva,
  output logic [ASID_W-1:0]    rpt_asid,
  output logic [VA_W-14:0]     rpt_vpn2,
  output logic [1:0]           rpt_vpn2x,
  output logic [VA_W-14:0]     rpt_ctx_vpn2
);
  localparam int PA_W    = PFN_W + 12;
  localparam int VPN2_W  = VA_W - 13;

  seg_e            seg;
  logic [PA_W-1:0] direct_pa;
  logic            uc_bits;
  logic            sel_valid;
  logic            sel_dirty;
  logic [PA_W-1:0] tlb_pa;
  flt_e            fault;
  logic            tlb_fault;
  logic [1:0]      vpn2x_src;

  logic [PA_W-1:0]   nx_paddr;
  logic              nx_uncached;
  logic [2:0]        nx_fault;
  logic [VA_W-1:0]   nx_badva;
  logic [ASID_W-1:0] nx_asid;
  logic [VPN2_W-1:0] nx_vpn2;
  logic [1:0]        nx_vpn2x;

  va_seg_dec #(.VA_W(VA_W), .PA_W(PA_W)) u_seg (
    .vaddr     (req_vaddr),
    .seg       (seg),
    .direct_pa (direct_pa),
    .uc_bits   (uc_bits)
  );

  va_half_sel #(.VA_W(VA_W), .PFN_W(PFN_W), .SZ_W(SZ_W), .MAX_SZ(MAX_SZ)) u_half (
    .vaddr     (req_vaddr),
    .size_code (tlb_size),
    .pfn_even  (tlb_pfn_even),
    .pfn_odd   (tlb_pfn_odd),
    .v_even    (tlb_v_even),
    .v_odd     (tlb_v_odd),
    .d_even    (tlb_d_even),
    .d_odd     (tlb_d_odd),
    .sel_valid (sel_valid),
    .sel_dirty (sel_dirty),
    .pa        (tlb_pa)
  );

  va_fault_cls u_cls (
    .seg       (seg),
    .acc       (req_acc),
    .kmode     (req_kmode),
    .misalign  (req_misalign),
    .hit       (tlb_hit),
    .sel_valid (sel_valid),
    .sel_dirty (sel_dirty),
    .fault     (fault),
    .tlb_fault (tlb_fault)
  );

  generate
    if (SMALL_PAGES) begin : g_small
      assign vpn2x_src = req_vaddr[12:11];
    end else begin : g_pair
      assign vpn2x_src = 2'b00;
    end
  endgenerate

  // next-state
  always_comb begin
    nx_fault    = fault;
    nx_paddr    = '0;
    nx_uncached = 1'b0;
    nx_badva    = '0;
    nx_asid     = '0;
    nx_vpn2     = '0;
    nx_vpn2x    = 2'b00;
    if (fault == FLT_NONE) begin
      nx_paddr    = (seg == SEG_MAPPED) ? tlb_pa : direct_pa;
      nx_uncached = uc_bits;
    end else begin
      nx_badva = req_vaddr;
      if (tlb_fault) begin
        nx_asid  = req_asid;
        nx_vpn2  = req_vaddr[VA_W-1:13];
        nx_vpn2x = vpn2x_src;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_paddr    <= '0;
      res_uncached <= 1'b0;
      res_fault    <= 3'd0;
      rpt_badva    <= '0;
      rpt_asid     <= '0;
      rpt_vpn2     <= '0;
      rpt_vpn2x    <= 2'b00;
      rpt_ctx_vpn2 <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_paddr    <= nx_paddr;
        res_uncached <= nx_uncached;
        res_fault    <= nx_fault;
        rpt_badva    <= nx_badva;
        rpt_asid     <= nx_asid;
        rpt_vpn2     <= nx_vpn2;
        rpt_vpn2x    <= nx_vpn2x;
        rpt_ctx_vpn2 <= nx_vpn2;
      end
    end
  end
endmodule

// File: rtl/va_xlate_chk.sv
module va_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [1:0]       req_acc,
  input logic             tlb_hit,
  input logic             res_valid,
  input logic [PA_W-1:0]  res_paddr,
  input logic             res_uncached,
  input logic [2:0]       res_fault,
  input logic [VA_W-14:0] rpt_vpn2
);
  a_r1_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_paddr) && $stable(res_fault)));

  a_r2_direct_uncached: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_vaddr[VA_W-1 -: 3]) == 3'b101)
      |-> (res_fault == 3'd0 && res_uncached));

  a_r5_refill_means_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_fault == 3'd3 || res_fault == 3'd4)) |-> !$past(tlb_hit));

  a_r8_modified_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 3'd7) |-> $past(req_acc) == 2'd2);

  a_r10_fault_clears_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 3'd0) |-> (res_paddr == '0 && !res_uncached));

  a_r11_vpn2_from_va: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault >= 3'd3) |-> rpt_vpn2 == $past(req_vaddr[VA_W-1:13]));
endmodule

bind va_xlate va_xlate_chk #(.VA_W(VA_W), .PA_W(PFN_W + 12)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_acc      (req_acc),
  .tlb_hit      (tlb_hit),
  .res_valid    (res_valid),
  .res_paddr    (res_paddr),
  .res_uncached (res_uncached),
  .res_fault    (res_fault),
  .rpt_vpn2     (rpt_vpn2)
);

// File: tb/sim_va_xlate.sv
module sim_va_xlate;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [7:0]  req_asid;
  logic [1:0]  req_acc;
  logic        req_kmode;
  logic        req_misalign;
  logic        tlb_hit;
  logic [2:0]  tlb_size;
  logic [19:0] tlb_pfn_even;
  logic [19:0] tlb_pfn_odd;
  logic        tlb_v_even, tlb_v_odd, tlb_d_even, tlb_d_odd;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_uncached;
  logic [2:0]  res_fault;
  logic [31:0] rpt_badva;
  logic [7:0]  rpt_asid;
  logic [18:0] rpt_vpn2;
  logic [1:0]  rpt_vpn2x;
  logic [18:0] rpt_ctx_vpn2;

  int n_checks = 0;
  int n_fail   = 0;

  va_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_asid(req_asid), .req_acc(req_acc), .req_kmode(req_kmode),
    .req_misalign(req_misalign), .tlb_hit(tlb_hit), .tlb_size(tlb_size),
    .tlb_pfn_even(tlb_pfn_even), .tlb_pfn_odd(tlb_pfn_odd),
    .tlb_v_even(tlb_v_even), .tlb_v_odd(tlb_v_odd),
    .tlb_d_even(tlb_d_even), .tlb_d_odd(tlb_d_odd),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_uncached(res_uncached),
    .res_fault(res_fault), .rpt_badva(rpt_badva), .rpt_asid(rpt_asid),
    .rpt_vpn2(rpt_vpn2), .rpt_vpn2x(rpt_vpn2x), .rpt_ctx_vpn2(rpt_ctx_vpn2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_entry(logic hit, logic [2:0] sz, logic [19:0] pe, logic [19:0] po,
                           logic ve, logic vo, logic de, logic dd);
    tlb_hit = hit; tlb_size = sz; tlb_pfn_even = pe; tlb_pfn_odd = po;
    tlb_v_even = ve; tlb_v_odd = vo; tlb_d_even = de; tlb_d_odd = dd;
  endtask

  task automatic fire(logic [31:0] va, logic [7:0] asid, logic [1:0] acc,
                      logic km, logic mis);
    @(negedge clk);
    req_vaddr = va; req_asid = asid; req_acc = acc; req_kmode = km;
    req_misalign = mis; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_ok(string req, logic [31:0] pa, logic uc);
    chk(req, "valid", {31'b0, res_valid}, 32'd1);
    chk(req, "fault", {29'b0, res_fault}, 32'd0);
    chk(req, "paddr", res_paddr, pa);
    chk(req, "uncached", {31'b0, res_uncached}, {31'b0, uc});
    chk(req, "badva", rpt_badva, 32'd0);
  endtask

  task automatic t_reset();
    chk("R12", "valid", {31'b0, res_valid}, 32'd0);
    chk("R12", "fault", {29'b0, res_fault}, 32'd0);
    chk("R12", "paddr", res_paddr, 32'd0);
    chk("R12", "badva", rpt_badva, 32'd0);
  endtask

  task automatic t_kseg1();
    set_entry(1'b0, 3'd0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    fire(32'hA123_4567, 8'h11, 2'd2, 1'b0, 1'b1); // R2: user, misaligned, miss
    expect_ok("R2", 32'h0123_4567, 1'b1);
  endtask

  task automatic t_kseg0();
    fire(32'h8000_1000, 8'h11, 2'd1, 1'b1, 1'b0);
    expect_ok("R3", 32'h0000_1000, 1'b0);
    fire(32'h8000_1000, 8'h11, 2'd0, 1'b0, 1'b0);
    chk("R3", "user fetch fault", {29'b0, res_fault}, 32'd1);
    chk("R11", "addr err badva", rpt_badva, 32'h8000_1000);
    chk("R11", "addr err asid zero", {24'b0, rpt_asid}, 32'd0);
    fire(32'h8000_1002, 8'h11, 2'd2, 1'b1, 1'b1);
    chk("R3", "misaligned store fault", {29'b0, res_fault}, 32'd2);
  endtask

  task automatic t_misalign_mapped();
    set_entry(1'b1, 3'd0, 20'h12345, 20'h0ABCD, 1'b1, 1'b1, 1'b1, 1'b1);
    fire(32'h0040_2001, 8'h22, 2'd1, 1'b1, 1'b1);
    chk("R4", "hit misaligned load", {29'b0, res_fault}, 32'd2);
    chk("R10", "fault paddr zero", res_paddr, 32'd0);
    set_entry(1'b0, 3'd0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    fire(32'h0040_2001, 8'h22, 2'd0, 1'b1, 1'b1);
    chk("R4", "miss misaligned fetch", {29'b0, res_fault}, 32'd1);
  endtask

  task automatic t_refill();
    set_entry(1'b0, 3'd0, 20'h0, 20'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    fire(32'h0040_6000, 8'h3C, 2'd1, 1'b0, 1'b0);
    chk("R5", "data refill", {29'b0, res_fault}, 32'd4);
    chk("R11", "asid", {24'b0, rpt_asid}, 32'h3C);
    chk("R11", "vpn2", {13'b0, rpt_vpn2}, 32'h203);
    chk("R11", "ctx vpn2", {13'b0, rpt_ctx_vpn2}, 32'h203);
    chk("R11", "vpn2x", {30'b0, rpt_vpn2x}, 32'd0);
    chk("R11", "badva", rpt_badva, 32'h0040_6000);
    fire(32'h0040_6000, 8'h3C, 2'd0, 1'b0, 1'b0);
    chk("R5", "fetch refill", {29'b0, res_fault}, 32'd3);
  endtask

  task automatic t_halves();
    set_entry(1'b1, 3'd0, 20'h12345, 20'h0ABCD, 1'b1, 1'b1, 1'b1, 1'b1);
    fire(32'h0040_2ABC, 8'h01, 2'd1, 1'b0, 1'b0);
    expect_ok("R6", 32'h1234_5ABC, 1'b0);
    fire(32'h0040_3ABC, 8'h01, 2'd1, 1'b0, 1'b0);
    expect_ok("R6", 32'h0ABC_DABC, 1'b0);
    set_entry(1'b1, 3'd1, 20'h12345, 20'h0ABCD, 1'b1, 1'b1, 1'b1, 1'b1);
    fire(32'h0041_6123, 8'h01, 2'd1, 1'b0, 1'b0); // R9: 16 KiB page, bit14 odd
    expect_ok("R9", 32'h0ABC_E123, 1'b0);
  endtask

  task automatic t_invalid_dirty();
    set_entry(1'b1, 3'd0, 20'h12345, 20'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b1);
    fire(32'h0040_2000, 8'h05, 2'd0, 1'b0, 1'b0);
    chk("R7", "fetch invalid", {29'b0, res_fault}, 32'd5);
    fire(32'h0040_2000, 8'h05, 2'd2, 1'b0, 1'b0);
    chk("R7", "store invalid beats clean", {29'b0, res_fault}, 32'd6);
    set_entry(1'b1, 3'd0, 20'h12345, 20'h0ABCD, 1'b1, 1'b1, 1'b0, 1'b1);
    fire(32'h0040_2010, 8'h05, 2'd2, 1'b0, 1'b0);
    chk("R8", "store clean", {29'b0, res_fault}, 32'd7);
    chk("R11", "mod asid", {24'b0, rpt_asid}, 32'h05);
    fire(32'h0040_2010, 8'h05, 2'd1, 1'b0, 1'b0);
    expect_ok("R8", 32'h1234_5010, 1'b0);
    fire(32'h0040_3010, 8'h05, 2'd2, 1'b0, 1'b0);
    expect_ok("R8", 32'h0ABC_D010, 1'b0);
  endtask

  task automatic t_mapped_uncached();
    set_entry(1'b1, 3'd0, 20'h00001, 20'h00002, 1'b1, 1'b1, 1'b1, 1'b1);
    fire(32'hE000_0123, 8'h07, 2'd1, 1'b1, 1'b0);
    expect_ok("R10", 32'h0000_1123, 1'b1);
    fire(32'hC000_0123, 8'h07, 2'd1, 1'b1, 1'b0);
    expect_ok("R10", 32'h0000_1123, 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    chk("R1", "valid low when idle", {31'b0, res_valid}, 32'd0);
    req_vaddr = 32'h0000_0000; req_misalign = 1'b1; tlb_hit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "paddr held", res_paddr, 32'h0000_1123);
    chk("R1", "fault held", {29'b0, res_fault}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_asid = '0; req_acc = '0;
    req_kmode = 1'b0; req_misalign = 1'b0;
    set_entry(1'b0, 3'd0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_kseg1();
    t_kseg0();
    t_misalign_mapped();
    t_refill();
    t_halves();
    t_invalid_dirty();
    t_mapped_uncached();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule